// File: doc/BRIEF.md
# Shift and Rotate Unit

This unit shifts or rotates one operand by a programmable number of single-bit steps. It performs one step per clock, with the carry flag taking part where the operation calls for it. One start pulse supplies everything the operation needs: the operand, a byte/word width select, a 3-bit operation code, a step count and the incoming flag set. The unit then reports busy until the last step is done. A one-cycle done pulse marks the point at which the result and the updated flag set are valid.

Seven operations are supported: logical left, logical right and arithmetic right shifts, plain rotates in both directions, and rotates through the carry bit in both directions. Carry, parity, zero, sign and overflow are produced at the selected width. In byte mode the upper half of the operand passes through untouched.

A zero count, or the reserved operation code, returns the operand and flags unchanged. The unit is meant to sit beside an execution datapath that already holds the operand and the flag word.

Top module: `srot_unit`

## Requirements
- R1: Out of reset, busy_o and done_o are 0 and data_o and flags_o are all zero. A start is accepted from the third rising clock edge after rst_n goes high.
- R2: A start pulse with a nonzero count N and an operation code from 0 to 6 is accepted when busy_o is 0 at a rising edge. busy_o is then 1 for the next N cycles. done_o is 1 for exactly one cycle, beginning at the N-th edge after the accepting edge, and busy_o is 0 in that cycle.
- R3: A start with count 0, or with operation code 7, raises done_o in the cycle after the accepting edge. data_o then equals data_i and flags_o equals flags_i as they were sampled.
- R4: A start_i pulse while busy_o is 1 is ignored. The running operation finishes with the result it would have produced without the pulse.
- R5: Codes 0, 1 and 2 select the shifts. Code 0 (logical left) moves each bit one place toward the MSB and fills the LSB with 0. Code 1 (logical right) moves each bit one place toward the LSB and fills the MSB with 0. Code 2 (arithmetic right) moves each bit toward the LSB and keeps the old MSB as the new MSB.
- R6: Code 3 (rotate left) moves the MSB into the LSB and into carry. Code 4 (rotate right) moves the LSB into the MSB and into carry.
- R7: Code 5 (rotate left through carry) moves the MSB into carry and the old carry into the LSB. Code 6 (rotate right through carry) moves the LSB into carry and the old carry into the MSB.
- R8: After each shift step, carry holds the bit that left the operand. After N steps it holds the last such bit.
- R9: With word_i=1, the operation acts on all 16 bits. With word_i=0, it acts on bits 7:0 only, and bits 15:8 of data_o equal bits 15:8 of data_i.
- R10: flags_o bit 0 is carry, bit 1 parity, bit 2 zero, bit 3 sign and bit 4 overflow. Zero is set when the result is 0 at the selected width, and sign is the MSB of the result at the selected width. Parity is set when bits 7:0 of the result hold an even number of ones.
- R11: Overflow comes from the last step. For codes 0, 3 and 5 it is set when the MSB changed. For code 1 it equals the MSB before the step. For code 2 it is 0. For codes 4 and 6 it is the XOR of the top two result bits.
- R12: While no start is accepted, data_o and flags_o keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 3 | Operation code (0 to 6, 7 reserved for pass-through) |
| word_i | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| count_i | input | 5 | Number of single-bit steps |
| data_i | input | 16 | Operand |
| flags_i | input | 5 | Incoming flag set, layout as in R10 |
| busy_o | output | 1 | Steps in progress |
| done_o | output | 1 | One-cycle pulse, result and flags valid |
| data_o | output | 16 | Result |
| flags_o | output | 5 | Resulting flag set |

## Verification
A stepping error in the operand register corrupts data_o at the done pulse and stays visible until the next start. A miscount in the step counter moves the done pulse away from the N-th edge, so it shows as wrong latency in the same operation. A carry register that holds a stale value appears a step later as the wrong bit entering a rotate through carry. Stimulus mixes many counts with rotates through carry and byte mode, so that such delayed corruption reaches the ports within one operation.

// File: rtl/srot_pkg.sv
package srot_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_NOP = 3'd7
  } srot_op_e;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic par;
    logic carry;
  } srot_flags_t;

  localparam int FLG_W = $bits(srot_flags_t);

endpackage

// File: rtl/srot_rst_sync.sv
module srot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/srot_lane.sv
module srot_lane
  import srot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  srot_op_e     op_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  always_comb begin
    res_o  = val_i;
    cout_o = cin_i;
    ovf_o  = 1'b0;
    case (op_i)
      OP_SHL: begin
        res_o  = {val_i[W-2:0], 1'b0};
        cout_o = val_i[W-1];
        ovf_o  = res_o[W-1] ^ val_i[W-1];
      end
      OP_SHR: begin
        res_o  = {1'b0, val_i[W-1:1]};
        cout_o = val_i[0];
        ovf_o  = val_i[W-1];
      end
      OP_SAR: begin
        res_o  = {val_i[W-1], val_i[W-1:1]};
        cout_o = val_i[0];
        ovf_o  = 1'b0;
      end
      OP_ROL: begin
        res_o  = {val_i[W-2:0], val_i[W-1]};
        cout_o = val_i[W-1];
        ovf_o  = res_o[W-1] ^ val_i[W-1];
      end
      OP_ROR: begin
        res_o  = {val_i[0], val_i[W-1:1]};
        cout_o = val_i[0];
        ovf_o  = res_o[W-1] ^ res_o[W-2];
      end
      OP_RCL: begin
        res_o  = {val_i[W-2:0], cin_i};
        cout_o = val_i[W-1];
        ovf_o  = res_o[W-1] ^ val_i[W-1];
      end
      OP_RCR: begin
        res_o  = {cin_i, val_i[W-1:1]};
        cout_o = val_i[0];
        ovf_o  = res_o[W-1] ^ res_o[W-2];
      end
      default: begin
        res_o  = val_i;
        cout_o = cin_i;
        ovf_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/srot_zsp.sv
module srot_zsp #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              word_i,
  output logic              zero_o,
  output logic              sign_o,
  output logic              par_o
);
  always_comb begin
    if (word_i) begin
      zero_o = (val_i == '0);
      sign_o = val_i[DATA_W-1];
    end else begin
      zero_o = (val_i[BYTE_W-1:0] == '0);
      sign_o = val_i[BYTE_W-1];
    end
    par_o = ~(^val_i[BYTE_W-1:0]);
  end
endmodule

// File: rtl/srot_seq.sv
module srot_seq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             run_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             load_o,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    load_o = start_i && !busy_q;
    step_o = busy_q;
    if (busy_q) begin
      cnt_n = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end else if (start_i) begin
      cnt_n = count_i;
      if (run_i && (count_i != '0)) busy_n = 1'b1;
      else                          done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              word_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [4:0]        flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic [4:0]        flags_o
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int NLANE  = 2;

  logic        rst_s;
  logic        load, step;
  srot_op_e    op_q, op_n;
  logic        word_q, word_n;
  logic [DATA_W-1:0] acc_q, acc_n, step_val;
  srot_flags_t flg_q, flg_n;

  logic [DATA_W-1:0] lane_res  [NLANE];
  logic [NLANE-1:0]  lane_cout;
  logic [NLANE-1:0]  lane_ovf;
  logic              zf, sf, pf;

  srot_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_s)
  );

  srot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_s),
    .start_i (start_i),
    .count_i (count_i),
    .run_i   (op_i != OP_NOP),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step)
  );

  // lane 0 works on the low byte, lane 1 on the full word
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = (g == 0) ? BYTE_W : DATA_W;
    logic [LW-1:0] r;
    srot_lane #(.W(LW)) u_lane (
      .val_i  (acc_q[LW-1:0]),
      .op_i   (op_q),
      .cin_i  (flg_q.carry),
      .res_o  (r),
      .cout_o (lane_cout[g]),
      .ovf_o  (lane_ovf[g])
    );
    assign lane_res[g] = DATA_W'(r);
  end

  always_comb begin
    if (word_q) step_val = lane_res[1];
    else        step_val = {acc_q[DATA_W-1:BYTE_W], lane_res[0][BYTE_W-1:0]};
  end

  srot_zsp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_zsp (
    .val_i  (step_val),
    .word_i (word_q),
    .zero_o (zf),
    .sign_o (sf),
    .par_o  (pf)
  );

  always_comb begin
    acc_n  = acc_q;
    flg_n  = flg_q;
    op_n   = op_q;
    word_n = word_q;
    if (load) begin
      acc_n  = data_i;
      flg_n  = srot_flags_t'(flags_i);
      op_n   = srot_op_e'(op_i);
      word_n = word_i;
    end else if (step) begin
      acc_n       = step_val;
      flg_n.carry = word_q ? lane_cout[1] : lane_cout[0];
      flg_n.ovf   = word_q ? lane_ovf[1]  : lane_ovf[0];
      flg_n.zero  = zf;
      flg_n.sign  = sf;
      flg_n.par   = pf;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (load || step) begin
      acc_q <= acc_n;
      flg_q <= flg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      op_q   <= OP_NOP;
      word_q <= 1'b0;
    end else if (load) begin
      op_q   <= op_n;
      word_q <= word_n;
    end
  end

  assign data_o  = acc_q;
  assign flags_o = flg_q;
endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [2:0]        op_i,
  input logic              word_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [DATA_W-1:0] data_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o,
  input logic [4:0]        flags_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic                     stepped_q, word_cap_q;
  logic [2:0]               op_cap_q;
  logic [DATA_W-BYTE_W-1:0] hi_cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepped_q  <= 1'b0;
      word_cap_q <= 1'b0;
      op_cap_q   <= '0;
      hi_cap_q   <= '0;
    end else if (start_i && !busy_o) begin
      stepped_q  <= (count_i != '0) && (op_i != 3'd7);
      word_cap_q <= word_i;
      op_cap_q   <= op_i;
      hi_cap_q   <= data_i[DATA_W-1:BYTE_W];
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o);

  assert_busy_to_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(data_o) && $stable(flags_o));

  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && stepped_q && word_cap_q |-> flags_o[2] == (data_o == '0));

  assert_sar_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && stepped_q && (op_cap_q == 3'd2) |-> !flags_o[4]);

  assert_upper_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !word_cap_q |-> data_o[DATA_W-1:BYTE_W] == hi_cap_q);
endmodule

bind srot_unit srot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_s),
  .start_i (start_i),
  .op_i    (op_i),
  .word_i  (word_i),
  .count_i (count_i),
  .data_i  (data_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .data_o  (data_o),
  .flags_o (flags_o)
);

// File: tb/sim_srot_unit.sv
`timescale 1ns/1ps
module sim_srot_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic        word_i;
  logic [4:0]  count_i;
  logic [15:0] data_i;
  logic [4:0]  flags_i;
  logic        busy_o, done_o;
  logic [15:0] data_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  srot_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .word_i(word_i),
    .count_i(count_i), .data_i(data_i), .flags_i(flags_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o), .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // returns {flags, data}; flag layout {ovf, sign, zero, par, carry}
  function automatic logic [20:0] model(input logic [2:0] op, input logic wd,
                                         input logic [4:0] cnt, input logic [15:0] d,
                                         input logic [4:0] f);
    int unsigned w, mask, x;
    logic c, o, z, s, p;
    if (cnt == 0 || op == 3'd7) return {f, d};
    w    = wd ? 16 : 8;
    mask = (1 << w) - 1;
    x    = d & mask;
    c    = f[0];
    o    = f[4];
    for (int i = 0; i < cnt; i++) begin
      logic top, bot, cold, nt, ns;
      top  = (x >> (w - 1)) & 1;
      bot  = x & 1;
      cold = c;
      case (op)
        3'd0: begin x = (x << 1) & mask; c = top; end
        3'd1: begin x = x >> 1; c = bot; end
        3'd2: begin x = (x >> 1) | (top << (w - 1)); c = bot; end
        3'd3: begin x = ((x << 1) | top) & mask; c = top; end
        3'd4: begin x = (x >> 1) | (bot << (w - 1)); c = bot; end
        3'd5: begin x = ((x << 1) | cold) & mask; c = top; end
        default: begin x = (x >> 1) | (cold << (w - 1)); c = bot; end
      endcase
      nt = (x >> (w - 1)) & 1;
      ns = (x >> (w - 2)) & 1;
      case (op)
        3'd0, 3'd3, 3'd5: o = nt ^ top;
        3'd1:             o = top;
        3'd2:             o = 1'b0;
        default:          o = nt ^ ns;
      endcase
    end
    z = ((x & mask) == 0);
    s = (x >> (w - 1)) & 1;
    p = ~(^x[7:0]);
    return {o, s, z, p, c, (wd ? x[15:0] : {d[15:8], x[7:0]})};
  endfunction

  function automatic string op_req(input logic [2:0] op, input logic [4:0] cnt);
    if (cnt == 0 || op == 3'd7) return "R3";
    if (op <= 3'd2) return "R5";
    if (op <= 3'd4) return "R6";
    return "R7";
  endfunction

  task automatic run_op(input logic [2:0] op, input logic wd, input logic [4:0] cnt,
                        input logic [15:0] d, input logic [4:0] f, input bit poke);
    logic [20:0] exp;
    bit stepped;
    string rq;
    exp     = model(op, wd, cnt, d, f);
    stepped = (cnt != 0) && (op != 3'd7);
    rq      = op_req(op, cnt);
    @(negedge clk);
    op_i = op; word_i = wd; count_i = cnt; data_i = d; flags_i = f; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!stepped) begin
      chk(done_o && !busy_o, "R3", "done after zero-step start", {busy_o, done_o}, 2'b01);
    end else begin
      for (int i = 0; i < cnt; i++) begin
        if (!busy_o || done_o) chk(1'b0, "R2", "busy window", {busy_o, done_o}, 2'b10);
        if (poke && i == 0) begin
          // R4: start during busy must be ignored
          start_i = 1'b1; data_i = ~d; count_i = 5'd0; op_i = 3'd0; flags_i = ~f;
        end
        @(negedge clk);
        start_i = 1'b0;
      end
      chk(done_o && !busy_o, "R2", "done at N-th edge", {busy_o, done_o}, 2'b01);
    end
    chk(data_o[7:0] == exp[7:0], poke ? "R4" : rq, "low byte", data_o, exp[15:0]);
    if (wd) chk(data_o == exp[15:0], rq, "word result", data_o, exp[15:0]);
    else    chk(data_o[15:8] == d[15:8], "R9", "upper byte kept", data_o, exp[15:0]);
    chk(flags_o[0] == exp[16], (stepped && op <= 3'd2) ? "R8" : rq, "carry",
        flags_o, exp[20:16]);
    chk(flags_o[3:1] == exp[19:17], "R10", "zero/sign/parity", flags_o, exp[20:16]);
    chk(flags_o[4] == exp[20], "R11", "overflow", flags_o, exp[20:16]);
    @(negedge clk);
    chk(!done_o, "R2", "done one cycle", done_o, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] hold_d;
    logic [4:0]  hold_f;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; word_i = 1'b0;
    count_i = '0; data_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R1", "reset handshake", {busy_o, done_o}, 2'b00);
    chk(data_o == 16'h0 && flags_o == 5'h0, "R1", "reset outputs",
        {flags_o, data_o}, 21'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners
    run_op(3'd0, 1'b0, 5'd1,  16'h1280, 5'h00, 1'b0); // byte SHL of 0x80
    run_op(3'd2, 1'b1, 5'd3,  16'h8001, 5'h00, 1'b0); // SAR keeps sign
    run_op(3'd1, 1'b1, 5'd1,  16'h8000, 5'h00, 1'b0); // SHR overflow = old msb
    run_op(3'd6, 1'b0, 5'd9,  16'hab5a, 5'h01, 1'b0); // RCR full 9-bit loop
    run_op(3'd5, 1'b1, 5'd17, 16'h0f0f, 5'h01, 1'b0); // RCL full 17-bit loop
    run_op(3'd3, 1'b1, 5'd16, 16'hc3a5, 5'h00, 1'b0); // ROL full word
    run_op(3'd4, 1'b0, 5'd1,  16'h7701, 5'h00, 1'b0); // ROR lsb to msb
    run_op(3'd7, 1'b1, 5'd5,  16'h1234, 5'h1b, 1'b0); // reserved code
    run_op(3'd0, 1'b1, 5'd0,  16'hffff, 5'h15, 1'b0); // zero count
    run_op(3'd3, 1'b0, 5'd4,  16'h5aa5, 5'h0a, 1'b1); // start while busy

    // R12: outputs hold without an accepted start
    hold_d = data_o; hold_f = flags_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      data_i = 16'($urandom); op_i = 3'($urandom); count_i = 5'($urandom);
    end
    chk(data_o == hold_d && flags_o == hold_f, "R12", "hold while idle",
        {flags_o, data_o}, {hold_f, hold_d});

    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      run_op(op, 1'($urandom), 5'($urandom % 20), 16'($urandom), 5'($urandom),
             ($urandom % 4) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule